// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block sits in the always-on domain of a small microcontroller and decides when the core may drop into its deepest power state and when it has to come back. A request arrives as a one-cycle strobe: wait-for-interrupt, wait-for-event or return from an interrupt handler. The block checks that request against the power control bits, the pending interrupt and event lines and the RTC flags of the selected wake sources, all in the same cycle. A request that passes turns on the standby-active output. A request that fails is dropped without any effect.

While standby is active, the block watches four kinds of exit source. The first is a rising edge on an enabled wakeup pin. The second is any selected RTC event. The third is the external reset pin and the fourth is the watchdog reset. An exit never resumes execution. The block clears standby and issues a one-cycle system reset request. A wake-flag or a standby-reset flag records the kind of exit. Both flags are held across the reset the block requests and are cleared by software. During standby the block also drives a per-pad high-impedance mask. The only pads that stay driven are the reset pad, the RTC alternate-function pad when that pad is configured, and the enabled wakeup pins.

Top module: `stby_seq`

## Requirements
- R1: With `stby_o` low, a `wfi_i` strobe raises `stby_o` on the next clock only if `deep_sleep_i`=1, `pd_sel_i`=1, `clr_flags_i`=0, `(rtc_flag_i & rtc_sel_i)`=0 and `irq_pend_i`=0. Otherwise `stby_o` stays low.
- R2: A `wfe_i` strobe follows the same rules as R1, except that `evt_pend_i`=1 blocks it and `irq_pend_i` is not looked at.
- R3: An `isr_ret_i` strobe raises `stby_o` on the next clock only if `deep_sleep_i`=1, `sleep_exit_i`=1, `pd_sel_i`=1, `wk_flag_o`=0, `(rtc_flag_i & rtc_sel_i)`=0 and `irq_pend_i`=0.
- R4: Once set, `stby_o` stays high until an exit source is seen. A wakeup pin k causes an exit only on a 0-to-1 change between two consecutive clock samples while `wk_en_i[k]`=1. A pin that is already high when standby starts causes no exit, and an edge on a disabled pin is ignored.
- R5: RTC flag bits are mapped as 0 alarm A, 1 alarm B, 2 periodic wakeup, 3 tamper, 4 timestamp. While in standby, a flag bit that is high with its `rtc_sel_i` bit set causes an exit. Unselected flags are ignored.
- R6: An exit source seen on a clock edge clears `stby_o` and raises `sys_rst_o` for exactly one cycle after that edge.
- R7: A pin or RTC exit sets `wk_flag_o`. The flag stays set until `clr_flags_i`=1 is seen with `stby_o` low.
- R8: An exit through `ext_rst_i` or `wdg_rst_i` sets `sb_flag_o` and leaves `wk_flag_o` unchanged. `sb_flag_o` is cleared the same way as `wk_flag_o`.
- R9: The pad map is bit 0 reset pad, bit 1 RTC alternate-function pad, and bits 2..4 wakeup pins 0..2. `pad_hiz_o` bit = 1 means high impedance. Outside standby `pad_hiz_o` is all zero. In standby every bit is 1 except bit 0, bit 1 when `rtc_af_on_i`=1, and bit 2+k when `wk_en_i[k]`=1.
- R10: After `rst_n` is deasserted, `stby_o`, `sys_rst_o`, both flags and `pad_hiz_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| isr_ret_i | input | 1 | Handler-return strobe |
| deep_sleep_i | input | 1 | Deep-sleep control bit |
| pd_sel_i | input | 1 | Power-down select bit |
| sleep_exit_i | input | 1 | Sleep-on-exit control bit |
| clr_flags_i | input | 1 | Clear-flags control bit |
| irq_pend_i | input | 1 | Interrupt pending |
| evt_pend_i | input | 1 | Event pending |
| rtc_flag_i | input | 5 | RTC event flags |
| rtc_sel_i | input | 5 | Selected RTC wake sources |
| wk_pin_i | input | 3 | Wakeup pin levels |
| wk_en_i | input | 3 | Wakeup pin enables |
| rtc_af_on_i | input | 1 | RTC alternate-function pad in use |
| ext_rst_i | input | 1 | External reset pin asserted |
| wdg_rst_i | input | 1 | Watchdog reset |
| stby_o | output | 1 | Standby active |
| sys_rst_o | output | 1 | One-cycle system reset request on exit |
| wk_flag_o | output | 1 | Woken by pin or RTC |
| sb_flag_o | output | 1 | Left standby through a reset source |
| pad_hiz_o | output | 16 | Per-pad high-impedance control |

## Verification
The assertions assume that the request strobes last a single cycle and that the control bits, pending lines and enables do not change in the cycle a strobe is presented. They also assume that `rst_n` is released synchronously. The bench drives every input on the falling clock edge and holds the control bits constant around each strobe. It returns all RTC flags and pins to zero before each new entry attempt, so a stale level cannot be mistaken for a fresh exit. Outputs are sampled on the falling edge that follows the edge which registers them.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int RTC_SRC_N = 5;

    typedef enum int {
        RTC_ALARM_A  = 0,
        RTC_ALARM_B  = 1,
        RTC_PERIODIC = 2,
        RTC_TAMPER   = 3,
        RTC_TSTAMP   = 4
    } rtc_src_e;

    typedef struct packed {
        logic standby;
        logic rst_req;
        logic wk_flag;
        logic sb_flag;
    } stby_state_t;

endpackage

// File: rtl/stby_entry_gate.sv
module stby_entry_gate #(
    parameter int N_RTC = 5
) (
    input  logic             wfi_i,
    input  logic             wfe_i,
    input  logic             isr_ret_i,
    input  logic             deep_sleep_i,
    input  logic             pd_sel_i,
    input  logic             sleep_exit_i,
    input  logic             clr_flags_i,
    input  logic             irq_pend_i,
    input  logic             evt_pend_i,
    input  logic [N_RTC-1:0] rtc_flag_i,
    input  logic [N_RTC-1:0] rtc_sel_i,
    input  logic             wk_flag_i,
    output logic             enter_o
);
    logic rtc_quiet;
    logic base_ok;
    logic wfi_ok;
    logic wfe_ok;
    logic isr_ok;

    always_comb begin
        rtc_quiet = ((rtc_flag_i & rtc_sel_i) == '0);
        base_ok   = deep_sleep_i && pd_sel_i && rtc_quiet;
        wfi_ok    = wfi_i && base_ok && !clr_flags_i && !irq_pend_i;
        wfe_ok    = wfe_i && base_ok && !clr_flags_i && !evt_pend_i;
        isr_ok    = isr_ret_i && base_ok && sleep_exit_i && !wk_flag_i && !irq_pend_i;
        enter_o   = wfi_ok || wfe_ok || isr_ok;
    end

endmodule

// File: rtl/stby_edge_det.sv
module stby_edge_det #(
    parameter int N_PIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [N_PIN-1:0] pin_i,
    input  logic [N_PIN-1:0] en_i,
    output logic [N_PIN-1:0] rise_o
);
    for (genvar k = 0; k < N_PIN; k++) begin : g_pin
        logic prev_d;
        logic prev_q;

        always_comb begin
            prev_d    = pin_i[k];
            rise_o[k] = arm_i && en_i[k] && pin_i[k] && !prev_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= prev_d;
        end

        a_r4_rise_needs_low_sample: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[k] |-> !$past(pin_i[k]));
    end

endmodule

// File: rtl/stby_pad_mask.sv
module stby_pad_mask #(
    parameter int N_PAD   = 16,
    parameter int N_PIN   = 3,
    parameter int RST_IDX = 0,
    parameter int RTC_IDX = 1,
    parameter int WK_BASE = 2
) (
    input  logic             standby_i,
    input  logic             rtc_af_on_i,
    input  logic [N_PIN-1:0] wk_en_i,
    output logic [N_PAD-1:0] hiz_o
);
    logic [N_PAD-1:0] keep;

    for (genvar p = 0; p < N_PAD; p++) begin : g_pad
        if (p == RST_IDX) begin : g_rst
            assign keep[p] = 1'b1;
        end else if (p == RTC_IDX) begin : g_rtc
            assign keep[p] = rtc_af_on_i;
        end else if (p >= WK_BASE && p < WK_BASE + N_PIN) begin : g_wk
            assign keep[p] = wk_en_i[p - WK_BASE];
        end else begin : g_gen
            assign keep[p] = 1'b0;
        end
    end

    always_comb hiz_o = standby_i ? ~keep : '0;

endmodule

// File: rtl/stby_seq.sv
module stby_seq
    import stby_pkg::*;
#(
    parameter int N_PIN   = 3,
    parameter int N_PAD   = 16,
    parameter int RST_PAD = 0,
    parameter int RTC_PAD = 1,
    parameter int WK_PAD0 = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wfi_i,
    input  logic                 wfe_i,
    input  logic                 isr_ret_i,
    input  logic                 deep_sleep_i,
    input  logic                 pd_sel_i,
    input  logic                 sleep_exit_i,
    input  logic                 clr_flags_i,
    input  logic                 irq_pend_i,
    input  logic                 evt_pend_i,
    input  logic [RTC_SRC_N-1:0] rtc_flag_i,
    input  logic [RTC_SRC_N-1:0] rtc_sel_i,
    input  logic [N_PIN-1:0]     wk_pin_i,
    input  logic [N_PIN-1:0]     wk_en_i,
    input  logic                 rtc_af_on_i,
    input  logic                 ext_rst_i,
    input  logic                 wdg_rst_i,
    output logic                 stby_o,
    output logic                 sys_rst_o,
    output logic                 wk_flag_o,
    output logic                 sb_flag_o,
    output logic [N_PAD-1:0]     pad_hiz_o
);
    stby_state_t st_d;
    stby_state_t st_q;
    logic             enter;
    logic [N_PIN-1:0] pin_rise;
    logic             pin_hit;
    logic             rtc_hit;
    logic             rst_hit;

    stby_entry_gate #(.N_RTC(RTC_SRC_N)) u_gate (
        .wfi_i        (wfi_i),
        .wfe_i        (wfe_i),
        .isr_ret_i    (isr_ret_i),
        .deep_sleep_i (deep_sleep_i),
        .pd_sel_i     (pd_sel_i),
        .sleep_exit_i (sleep_exit_i),
        .clr_flags_i  (clr_flags_i),
        .irq_pend_i   (irq_pend_i),
        .evt_pend_i   (evt_pend_i),
        .rtc_flag_i   (rtc_flag_i),
        .rtc_sel_i    (rtc_sel_i),
        .wk_flag_i    (st_q.wk_flag),
        .enter_o      (enter)
    );

    stby_edge_det #(.N_PIN(N_PIN)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (st_q.standby),
        .pin_i  (wk_pin_i),
        .en_i   (wk_en_i),
        .rise_o (pin_rise)
    );

    stby_pad_mask #(
        .N_PAD   (N_PAD),
        .N_PIN   (N_PIN),
        .RST_IDX (RST_PAD),
        .RTC_IDX (RTC_PAD),
        .WK_BASE (WK_PAD0)
    ) u_pad (
        .standby_i   (st_q.standby),
        .rtc_af_on_i (rtc_af_on_i),
        .wk_en_i     (wk_en_i),
        .hiz_o       (pad_hiz_o)
    );

    always_comb begin
        pin_hit = |pin_rise;
        rtc_hit = |(rtc_flag_i & rtc_sel_i);
        rst_hit = ext_rst_i || wdg_rst_i;

        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (!st_q.standby) begin
            if (clr_flags_i) begin
                st_d.wk_flag = 1'b0;
                st_d.sb_flag = 1'b0;
            end
            if (enter) st_d.standby = 1'b1;
        end else if (pin_hit || rtc_hit || rst_hit) begin
            st_d.standby = 1'b0;
            st_d.rst_req = 1'b1;
            if (pin_hit || rtc_hit) st_d.wk_flag = 1'b1;
            if (rst_hit)            st_d.sb_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stby_o    = st_q.standby;
    assign sys_rst_o = st_q.rst_req;
    assign wk_flag_o = st_q.wk_flag;
    assign sb_flag_o = st_q.sb_flag;

    a_r1_entry_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stby_o) |-> $past(wfi_i || wfe_i || isr_ret_i));

    a_r1_irq_blocks_wfi: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby_o && wfi_i && !wfe_i && !isr_ret_i && irq_pend_i) |=> !stby_o);

    a_r6_reset_follows_exit: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> ($past(stby_o) && !stby_o));

    a_r6_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);

    a_r7_wake_flag_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wk_flag_o) |-> $fell(stby_o));

    a_r8_sb_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sb_flag_o) |-> $past(ext_rst_i || wdg_rst_i));

    a_r9_reset_pad_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_hiz_o[RST_PAD]);

    a_r9_idle_all_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_o |-> (pad_hiz_o == '0));

endmodule

// File: tb/stby_seq_test.sv
module stby_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wfi = 0, wfe = 0, isr_ret = 0;
    logic       deep = 0, pd = 0, soe = 0, clr = 0;
    logic       irq_p = 0, evt_p = 0;
    logic [4:0] rtc_flag = '0, rtc_sel = '0;
    logic [2:0] pin = '0, en = '0;
    logic       rtc_af = 0, ext_rst = 0, wdg = 0;
    logic        stby, sys_rst, wkf, sbf;
    logic [15:0] hiz;
    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    stby_seq uut (
        .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .isr_ret_i(isr_ret),
        .deep_sleep_i(deep), .pd_sel_i(pd), .sleep_exit_i(soe), .clr_flags_i(clr),
        .irq_pend_i(irq_p), .evt_pend_i(evt_p), .rtc_flag_i(rtc_flag), .rtc_sel_i(rtc_sel),
        .wk_pin_i(pin), .wk_en_i(en), .rtc_af_on_i(rtc_af), .ext_rst_i(ext_rst),
        .wdg_rst_i(wdg), .stby_o(stby), .sys_rst_o(sys_rst), .wk_flag_o(wkf),
        .sb_flag_o(sbf), .pad_hiz_o(hiz)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        wfi = 0; wfe = 0; isr_ret = 0; deep = 1; pd = 1; soe = 0; clr = 0;
        irq_p = 0; evt_p = 0; rtc_flag = '0; pin = '0; ext_rst = 0; wdg = 0;
    endtask

    task automatic enter_wfi();
        wfi = 1; step(); wfi = 0;
    endtask

    task automatic exit_seq(input string req, input logic exp_wk, input logic exp_sb);
        step();
        chk({req, " standby dropped"}, stby, 0);
        chk({req, " R6 reset pulse"}, sys_rst, 1);
        chk({req, " wake flag"}, wkf, exp_wk);
        chk({req, " sb flag"}, sbf, exp_sb);
        quiet();
        step();
        chk({req, " R6 pulse ends"}, sys_rst, 0);
        chk({req, " R7 flag held"}, wkf, exp_wk);
        clr = 1; step(); clr = 0;
        chk({req, " R7 flags cleared"}, {wkf, sbf}, 0);
    endtask

    task automatic t_reset();
        chk("R10 reset outputs", {stby, sys_rst, wkf, sbf}, 0);
        chk("R10 reset pads", hiz, 0);
    endtask

    task automatic t_refusals();
        quiet(); rtc_sel = 5'b00001;
        deep = 0; enter_wfi(); chk("R1 no deep-sleep", stby, 0); quiet();
        pd = 0;   enter_wfi(); chk("R1 no power-down", stby, 0); quiet();
        clr = 1;  enter_wfi(); clr = 0; chk("R1 clear bit set", stby, 0); quiet();
        rtc_flag = 5'b00001; enter_wfi(); chk("R1 selected rtc flag", stby, 0); quiet();
        irq_p = 1; enter_wfi(); chk("R1 irq pending", stby, 0); quiet();
        evt_p = 1; wfe = 1; step(); wfe = 0; chk("R2 event pending", stby, 0); quiet();
        isr_ret = 1; step(); isr_ret = 0; chk("R3 no sleep-on-exit", stby, 0); quiet();
        soe = 1; irq_p = 1; isr_ret = 1; step(); isr_ret = 0;
        chk("R3 irq pending", stby, 0); quiet();
    endtask

    task automatic t_wfe_entry();
        quiet(); irq_p = 1; wfe = 1; step(); wfe = 0;
        chk("R2 wfe entry ignores irq", stby, 1);
        irq_p = 0; pin = 3'b001; en = 3'b001; step(); pin = 0;
        chk("R4 pin0 wakes", stby, 0);
        chk("R6 reset on pin wake", sys_rst, 1);
        step(); chk("R7 wake flag set", wkf, 1);
        quiet(); soe = 1; isr_ret = 1; step(); isr_ret = 0;
        chk("R3 refused with wake flag", stby, 0);
        clr = 1; step(); clr = 0;
        chk("R7 cleared", wkf, 0);
    endtask

    task automatic t_isr_entry();
        quiet(); soe = 1; isr_ret = 1; step(); isr_ret = 0;
        chk("R3 isr entry", stby, 1);
        wdg = 1;
        exit_seq("R8 watchdog", 0, 1);
    endtask

    task automatic t_pins();
        quiet(); en = 3'b101; pin = 3'b001;
        enter_wfi(); chk("R1 wfi entry", stby, 1);
        step(); step();
        chk("R4 pin high at entry no wake", stby, 1);
        pin = 3'b011; step();
        chk("R4 disabled pin1 ignored", stby, 1);
        pin = 3'b010; step();
        chk("R4 falling edge ignored", stby, 1);
        pin = 3'b110;
        exit_seq("R4 pin2 rising", 1, 0);
    endtask

    task automatic t_rtc();
        for (int b = 0; b < 5; b++) begin
            quiet(); rtc_sel = 5'(1 << b);
            enter_wfi(); chk("R1 entry for rtc", stby, 1);
            rtc_flag = ~rtc_sel; step();
            chk("R5 unselected flags ignored", stby, 1);
            rtc_flag = rtc_sel;
            exit_seq("R5 rtc source", 1, 0);
        end
    endtask

    task automatic t_ext_reset();
        quiet(); enter_wfi(); chk("R1 entry", stby, 1);
        ext_rst = 1;
        exit_seq("R8 external reset", 0, 1);
    endtask

    task automatic t_pads();
        logic [15:0] exp;
        for (int c = 0; c < 4; c++) begin
            quiet(); rtc_sel = '0;
            rtc_af = c[0];
            en = (c == 0) ? 3'b000 : (c == 1) ? 3'b010 : (c == 2) ? 3'b101 : 3'b111;
            enter_wfi();
            exp = 16'hFFFE;
            if (rtc_af) exp[1] = 1'b0;
            for (int k = 0; k < 3; k++) if (en[k]) exp[2 + k] = 1'b0;
            chk("R9 standby pad mask", hiz, 32'(exp));
            ext_rst = 1; step(); quiet();
            chk("R9 pads released", hiz, 0);
            clr = 1; step(); clr = 0;
        end
        rtc_af = 0; en = '0;
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_refusals();
        t_wfe_entry();
        t_isr_entry();
        t_pins();
        t_rtc();
        t_ext_reset();
        t_pads();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule